// File: doc/BRIEF.md
# Interrupt Control Instruction Unit

This block sits next to a small in-order core and carries out the custom interrupt-control instructions that use the custom0 major opcode with funct3 equal to zero. The core shows it the instruction in decode, the value read for the rs1 field, and the PC of that instruction. The block answers in the same cycle with a register write-back, a stall request or a PC redirect. It keeps four scratch q-registers, a 32-bit interrupt mask in which a set bit disables a source, an interrupt-enable flag, and a pending register fed by 32 interrupt lines.

Interrupts are taken at instruction boundaries, meaning any cycle in which the core presents a valid instruction. When an interrupt is taken, the presented instruction is not executed. The return PC goes to q0 and the taken bits go to q1. The taken pending bits are cleared, interrupts are disabled, and the core is sent to a fixed handler address. Line 0 is the timer, line 1 is illegal instruction and line 2 is bus error. An illegal-instruction or bus-error event that arrives while its own source is masked stops the block for good.

Top module: `irqu_unit`

## Requirements
- R1: An instruction is claimed only when bits [6:0] equal 0001011 and bits [14:12] equal 000. Any other word produces no write-back, no redirect and no stall.
- R2: funct7 (bits [31:25]) 0000000 reads a q-register. The index is bits [16:15]. The value is returned on `rd_data` with `rd_we` high.
- R3: funct7 0000001 loads `rs1_val` into the q-register indexed by bits [8:7]. It does not write back.
- R4: funct7 0000010 redirects the PC to the value of q0 and sets interrupts enabled again.
- R5: funct7 0000011 swaps the mask. `rs1_val` becomes the new mask and the old mask is written back. A pending source whose mask bit is set is never taken.
- R6: After reset every mask bit is set, all q-registers read zero, interrupts are enabled, nothing is pending, and `halt` is low.
- R7: funct7 0000100 stalls while no interrupt is pending. Once any pending bit is set, regardless of the mask, it writes back the pending bitmask without stalling.
- R8: A high level on interrupt line n sets pending bit n. The bit stays set until it is taken. Bit 0 is the timer, bit 1 is illegal instruction, bit 2 is bus error.
- R9: When interrupts are enabled, an unmasked bit is pending and a valid instruction is presented, the block does four things. It redirects to `HANDLER_PC` without write-back. It stores `cur_pc` in q0 and the taken bits in q1. It clears those pending bits. It disables interrupts.
- R10: While interrupts are disabled, no interrupt is taken, even if unmasked bits are pending.
- R11: A claimed instruction with any other funct7 raises pending bit 1, the illegal-instruction event.
- R12: An event on line 1 or line 2, or an internal illegal event, that occurs while that bit is masked sets `halt` permanently until reset. While halted, `stall` is high and nothing executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Core presents an instruction (instruction boundary) |
| insn | input | 32 | Instruction word in decode |
| rs1_val | input | 32 | Register value read for the rs1 field |
| cur_pc | input | 32 | PC of the presented instruction |
| irq_lines | input | 32 | Interrupt request lines, high for one or more cycles |
| rd_we | output | 1 | Write-back valid |
| rd_data | output | 32 | Write-back value |
| stall | output | 1 | Hold the core in decode |
| pc_redir | output | 1 | Redirect the PC this cycle |
| pc_target | output | 32 | Redirect target |
| halt | output | 1 | Sticky stop after a masked fatal event |

## Verification
The checker watches several properties on every cycle. It confirms that unclaimed and idle cycles stay quiet and that a halted unit never writes back or redirects. It confirms that `halt` never falls and that a stall only comes from the wait instruction or from halt. It also confirms that a completed wait returns a non-zero bitmask and that a read of a q-register always writes back. Only the bench scenarios can show the data relations. These are the register contents across set and read, the mask swap history, the values saved in q0 and q1 on entry, the per-line clearing of pending bits, the blocking of nested entry until return, and which events stop the unit.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;
  localparam logic [6:0] F7_GETQ     = 7'b0000000;
  localparam logic [6:0] F7_SETQ     = 7'b0000001;
  localparam logic [6:0] F7_RETIRQ   = 7'b0000010;
  localparam logic [6:0] F7_MASK     = 7'b0000011;
  localparam logic [6:0] F7_WAIT     = 7'b0000100;

  typedef enum logic [2:0] {
    OP_NONE, OP_GETQ, OP_SETQ, OP_RET, OP_MASK, OP_WAIT, OP_BAD
  } irqu_op_e;
endpackage

// File: rtl/irqu_decode.sv
module irqu_decode
  import irqu_pkg::*;
(
  input  logic [31:0] insn,
  output irqu_op_e    op
);
  logic claimed;

  always_comb begin
    claimed = (insn[6:0] == OPC_CUSTOM0) && (insn[14:12] == 3'b000);
    op = OP_NONE;
    if (claimed) begin
      case (insn[31:25])
        F7_GETQ:   op = OP_GETQ;
        F7_SETQ:   op = OP_SETQ;
        F7_RETIRQ: op = OP_RET;
        F7_MASK:   op = OP_MASK;
        F7_WAIT:   op = OP_WAIT;
        default:   op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/irqu_qregs.sv
module irqu_qregs #(
  parameter int XLEN = 32,
  parameter int NQ   = 4,
  localparam int QW  = $clog2(NQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [QW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_en,
  input  logic [XLEN-1:0] save_pc,
  input  logic [XLEN-1:0] save_bits,
  input  logic [QW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] q0_val
);
  logic [XLEN-1:0] q_r   [NQ];
  logic [XLEN-1:0] q_nxt [NQ];
  logic            q_en  [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    always_comb begin
      q_en[g]  = wr_en && (wr_idx == QW'(g));
      q_nxt[g] = wr_data;
      if (save_en && g == 0) begin
        q_en[g]  = 1'b1;
        q_nxt[g] = save_pc;
      end else if (save_en && g == 1) begin
        q_en[g]  = 1'b1;
        q_nxt[g] = save_bits;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_r[g] <= '0;
      else if (q_en[g])  q_r[g] <= q_nxt[g];
    end
  end

  assign rd_data = q_r[rd_idx];
  assign q0_val  = q_r[0];
endmodule

// File: rtl/irqu_pending.sv
module irqu_pending #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] events,
  input  logic [NIRQ-1:0] take_bits,
  output logic [NIRQ-1:0] pend
);
  logic [NIRQ-1:0] pend_nxt;

  always_comb pend_nxt = (pend & ~take_bits) | events;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end
endmodule

// File: rtl/irqu_unit.sv
module irqu_unit
  import irqu_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] irq_lines,
  output logic            rd_we,
  output logic [XLEN-1:0] rd_data,
  output logic            stall,
  output logic            pc_redir,
  output logic [XLEN-1:0] pc_target,
  output logic            halt
);
  localparam int NQ = 4;
  localparam int QW = $clog2(NQ);
  localparam logic [XLEN-1:0] FATAL_BITS = XLEN'(3'b110);
  localparam logic [XLEN-1:0] ILL_BIT    = XLEN'(3'b010);

  irqu_op_e        op;
  logic [XLEN-1:0] mask_r, mask_nxt;
  logic            ien_r, ien_nxt;
  logic            halt_r, halt_nxt;
  logic [XLEN-1:0] pend, unmasked, take_bits, events;
  logic [XLEN-1:0] q_rd, q0_val;
  logic            live, take, exec, bad, wait_done;

  irqu_decode u_dec (.insn(insn), .op(op));

  irqu_qregs #(.XLEN(XLEN), .NQ(NQ)) u_q (
    .clk(clk), .rst_n(rst_n),
    .wr_en(exec && op == OP_SETQ), .wr_idx(insn[7 +: QW]), .wr_data(rs1_val),
    .save_en(take), .save_pc(cur_pc), .save_bits(unmasked),
    .rd_idx(insn[15 +: QW]), .rd_data(q_rd), .q0_val(q0_val)
  );

  irqu_pending #(.NIRQ(XLEN)) u_pend (
    .clk(clk), .rst_n(rst_n), .events(events), .take_bits(take_bits), .pend(pend)
  );

  always_comb begin
    live      = insn_valid && !halt_r;
    unmasked  = pend & ~mask_r;
    take      = live && ien_r && (|unmasked);
    take_bits = take ? unmasked : '0;
    exec      = live && !take;
    bad       = exec && op == OP_BAD;
    events    = irq_lines | (bad ? ILL_BIT : '0);
    wait_done = |pend;

    rd_we   = 1'b0;
    rd_data = '0;
    if (exec) begin
      case (op)
        OP_GETQ: begin rd_we = 1'b1; rd_data = q_rd;   end
        OP_MASK: begin rd_we = 1'b1; rd_data = mask_r; end
        OP_WAIT: begin rd_we = wait_done; rd_data = wait_done ? pend : '0; end
        default: ;
      endcase
    end

    stall     = halt_r || (exec && op == OP_WAIT && !wait_done);
    pc_redir  = take || (exec && op == OP_RET);
    pc_target = take ? HANDLER_PC : q0_val;

    mask_nxt = (exec && op == OP_MASK) ? rs1_val : mask_r;
    ien_nxt  = ien_r;
    if (take)                     ien_nxt = 1'b0;
    else if (exec && op == OP_RET) ien_nxt = 1'b1;
    halt_nxt = halt_r || (|(events & mask_r & FATAL_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= '1;
      ien_r  <= 1'b1;
      halt_r <= 1'b0;
    end else begin
      mask_r <= mask_nxt;
      ien_r  <= ien_nxt;
      halt_r <= halt_nxt;
    end
  end

  assign halt = halt_r;
endmodule

// File: rtl/irqu_chk.sv
module irqu_chk
  import irqu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_valid,
  input logic [31:0]     insn,
  input logic            rd_we,
  input logic [XLEN-1:0] rd_data,
  input logic            stall,
  input logic            pc_redir,
  input logic            halt
);
  logic claimed, is_wait, is_getq;
  assign claimed = insn[6:0] == OPC_CUSTOM0 && insn[14:12] == 3'b000;
  assign is_wait = claimed && insn[31:25] == F7_WAIT;
  assign is_getq = claimed && insn[31:25] == F7_GETQ;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_valid && !halt) |-> (!rd_we && !pc_redir && !stall));
  // R1
  unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !claimed && !halt) |-> (!rd_we && !stall));
  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  // R12
  halted_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (stall && !rd_we && !pc_redir));
  // R7
  stall_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (halt || (insn_valid && is_wait)));
  // R7
  wait_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && is_wait && rd_we) |-> (rd_data != '0 && !stall));
  // R2
  getq_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && is_getq && !halt && !pc_redir) |-> rd_we);
endmodule

bind irqu_unit irqu_chk #(.XLEN(XLEN)) u_irqu_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
  .rd_we(rd_we), .rd_data(rd_data), .stall(stall), .pc_redir(pc_redir), .halt(halt)
);

// File: tb/irqu_unit_bench.sv
`timescale 1ns/1ps
module irqu_unit_bench;
  localparam logic [31:0] HPC = 32'h0000_0010;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] insn, rs1_val, cur_pc, irq_lines;
  logic        rd_we, stall, pc_redir, halt;
  logic [31:0] rd_data, pc_target;
  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles++;

  irqu_unit #(.XLEN(32), .HANDLER_PC(HPC)) u_irqu_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rs1_val(rs1_val), .cur_pc(cur_pc), .irq_lines(irq_lines),
    .rd_we(rd_we), .rd_data(rd_data), .stall(stall), .pc_redir(pc_redir),
    .pc_target(pc_target), .halt(halt)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rsf,
                                     input logic [4:0] rdf);
    return {f7, 5'd0, rsf, 3'b000, rdf, 7'b0001011};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] i, input logic [31:0] r,
                       input logic [31:0] pc, input logic [31:0] l);
    @(negedge clk);
    insn_valid = v; insn = i; rs1_val = r; cur_pc = pc; irq_lines = l;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; insn_valid = 1'b0; insn = NOP; rs1_val = '0; cur_pc = '0; irq_lines = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
    finish_run();
  end

  initial begin
    logic [31:0] prev, pc1, pc2;
    do_reset();
    // R6 reset state
    drive(1'b0, NOP, 0, 0, 0);
    chk("R6 halt", {31'd0, halt}, 0);
    chk("R6 stall", {31'd0, stall}, 0);
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, mk(7'b0000000, 5'(i), 5'd1), 0, 0, 0);
      chk("R6 q zero", rd_data, 0);
    end
    drive(1'b1, mk(7'b0000011, 5'd0, 5'd1), 32'h0, 0, 0);
    chk("R6 mask all ones", rd_data, 32'hFFFF_FFFF);
    chk("R5 swap we", {31'd0, rd_we}, 1);

    // R3 / R2 q-register sweep
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, mk(7'b0000001, 5'd3, 5'(i)), 32'h1357_0000 ^ (32'(i) * 32'h0101_0101), 0, 0);
      chk("R3 setq no writeback", {31'd0, rd_we}, 0);
    end
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, mk(7'b0000000, 5'(i), 5'd2), 0, 0, 0);
      chk("R2 getq value", rd_data, 32'h1357_0000 ^ (32'(i) * 32'h0101_0101));
    end

    // R5 mask swap sweep
    prev = 32'h0;
    for (int k = 0; k < 32; k++) begin
      drive(1'b1, mk(7'b0000011, 5'd4, 5'd4), (32'h1 << k) ^ 32'h0F0F_0000, 0, 0);
      chk("R5 old mask", rd_data, prev);
      prev = (32'h1 << k) ^ 32'h0F0F_0000;
    end
    drive(1'b1, mk(7'b0000011, 5'd4, 5'd4), 32'h0, 0, 0);
    chk("R5 old mask last", rd_data, prev);

    // R1 unclaimed words
    drive(1'b1, {7'b0000010, 5'd0, 5'd0, 3'b001, 5'd0, 7'b0001011}, 0, 0, 0);
    chk("R1 funct3 nonzero", {29'd0, rd_we, pc_redir, stall}, 0);
    drive(1'b1, 32'h0020_80B3, 0, 0, 0);
    chk("R1 other opcode", {29'd0, rd_we, pc_redir, stall}, 0);

    // R8 / R9 / R10 / R4 entry sweep over every line
    for (int k = 0; k < 32; k++) begin
      pc1 = 32'h200 + 32'(k) * 4;
      pc2 = 32'h800 + 32'(k) * 4;
      drive(1'b0, NOP, 0, 0, 32'h1 << k);
      chk("R8 no redirect without boundary", {31'd0, pc_redir}, 0);
      drive(1'b1, NOP, 0, pc1, 0);
      chk("R9 entry redirect", {30'd0, pc_redir, rd_we}, 2);
      chk("R9 handler target", pc_target, HPC);
      drive(1'b1, mk(7'b0000000, 5'd0, 5'd1), 0, 0, 0);
      chk("R9 q0 saved pc", rd_data, pc1);
      drive(1'b1, mk(7'b0000000, 5'd1, 5'd1), 0, 0, 0);
      chk("R9 q1 taken bits", rd_data, 32'h1 << k);
      drive(1'b0, NOP, 0, 0, 32'h1 << ((k + 3) % 32));
      drive(1'b1, NOP, 0, 0, 0);
      chk("R10 no nested entry", {31'd0, pc_redir}, 0);
      drive(1'b1, mk(7'b0000010, 5'd0, 5'd0), 0, 0, 0);
      chk("R4 retirq redirect", {31'd0, pc_redir}, 1);
      chk("R4 retirq target", pc_target, pc1);
      drive(1'b1, NOP, 0, pc2, 0);
      chk("R4 re-enabled entry", {31'd0, pc_redir}, 1);
      drive(1'b1, mk(7'b0000000, 5'd1, 5'd1), 0, 0, 0);
      chk("R8 first bit cleared", rd_data, 32'h1 << ((k + 3) % 32));
      drive(1'b1, mk(7'b0000010, 5'd0, 5'd0), 0, 0, 0);
      chk("R4 second return", pc_target, pc2);
    end

    // R7 wait with masked pending, then R5 unmask
    drive(1'b1, mk(7'b0000011, 5'd0, 5'd0), 32'hFFFF_FFFF, 0, 0);
    drive(1'b1, mk(7'b0000100, 5'd0, 5'd5), 0, 0, 0);
    chk("R7 stall while none pending", {30'd0, stall, rd_we}, 2);
    drive(1'b1, mk(7'b0000100, 5'd0, 5'd5), 0, 0, 32'h200);
    chk("R7 stall on arrival cycle", {31'd0, stall}, 1);
    drive(1'b1, mk(7'b0000100, 5'd0, 5'd5), 0, 0, 0);
    chk("R7 wait completes", {30'd0, stall, rd_we}, 1);
    chk("R7 wait bitmask", rd_data, 32'h200);
    drive(1'b1, NOP, 0, 32'h40, 0);
    chk("R5 masked not taken", {31'd0, pc_redir}, 0);
    drive(1'b1, mk(7'b0000011, 5'd0, 5'd0), ~32'h200, 0, 0);
    chk("R5 swap returns ones", rd_data, 32'hFFFF_FFFF);
    drive(1'b1, NOP, 0, 32'h44, 0);
    chk("R5 unmasked taken", {31'd0, pc_redir}, 1);
    drive(1'b1, mk(7'b0000010, 5'd0, 5'd0), 0, 0, 0);

    // R11 unsupported funct7
    drive(1'b1, mk(7'b0000011, 5'd0, 5'd0), 32'h0, 0, 0);
    chk("R5 mask history", rd_data, ~32'h200);
    drive(1'b1, mk(7'b0001000, 5'd0, 5'd0), 0, 0, 0);
    chk("R11 no action", {30'd0, rd_we, pc_redir}, 0);
    drive(1'b1, NOP, 0, 32'h60, 0);
    chk("R11 illegal entry", {31'd0, pc_redir}, 1);
    drive(1'b1, mk(7'b0000000, 5'd1, 5'd1), 0, 0, 0);
    chk("R11 bit1 taken", rd_data, 32'h2);
    drive(1'b1, mk(7'b0000010, 5'd0, 5'd0), 0, 0, 0);

    // R12 masked illegal halts
    drive(1'b1, mk(7'b0000011, 5'd0, 5'd0), 32'h2, 0, 0);
    drive(1'b1, mk(7'b0000111, 5'd0, 5'd0), 0, 0, 0);
    chk("R12 not yet halted", {31'd0, halt}, 0);
    for (int n = 0; n < 3; n++) begin
      drive(1'b1, mk(7'b0000000, 5'd0, 5'd1), 0, 0, 0);
      chk("R12 halted", {29'd0, halt, stall, rd_we}, 6);
    end

    // R12 bus error line while masked; masked timer is harmless (R8)
    do_reset();
    drive(1'b0, NOP, 0, 0, 32'h1);
    drive(1'b0, NOP, 0, 0, 0);
    chk("R8 masked timer no halt", {31'd0, halt}, 0);
    drive(1'b0, NOP, 0, 0, 32'h4);
    drive(1'b0, NOP, 0, 0, 0);
    chk("R12 bus error halts", {30'd0, halt, stall}, 3);
    drive(1'b1, mk(7'b0000010, 5'd0, 5'd0), 0, 0, 0);
    chk("R12 no redirect halted", {31'd0, pc_redir}, 0);

    finish_run();
  end
endmodule